// File: doc/BRIEF.md
# Debug Register Write Command Decoder

This block sits between a debug serial channel and the debug register file of a processor core. The channel's bit-level shifter delivers complete 16-bit words together with a one-cycle valid strobe. The block watches those words for the debug-register write command. When it sees one, it collects the two operand words that follow and then issues a single write strobe to the register file, carrying a register index and 32 bits of data.

A second write source comes from the core, which can execute a privileged instruction that writes a debug register. Such a write is accepted only when two things are true: the serial debug clock is inactive, and the serial decoder is not in the middle of a command. A request that breaks either rule is dropped and reported on a busy-error pulse. A word that arrives while the decoder is idle and is not a write command is reported on an illegal-command pulse and otherwise discarded.

The two paths are merged onto one write port. The merge is ordered so that at most one write reaches the register file in any cycle.

Top module: `dbg_wr_decoder`

## Requirements
- R1: While and after reset, `wr_o`, `illegal_o` and `busy_err_o` are low and the serial decoder is idle, so a legal core write issued in the first cycle after reset is accepted.
- R2: A word accepted while idle is a write command when its bits 15:12 are 0x2, bits 11:8 are 0xC and bits 7:4 are 0x4. Its bits 3:0 give the target register index, carried on `wr_idx_o`.
- R3: The first word accepted after the command supplies data bits 31:16 and the second supplies data bits 15:0. `wr_o` is high for exactly one cycle, the cycle after the clock edge that accepts the second operand word, with the full 32-bit value on `wr_data_o`.
- R4: No write is issued before both operand words have been accepted. Cycles without `ser_vld_i` between the words only delay the write.
- R5: A word accepted while idle whose bits 15:4 differ from 0x2C4 gives a one-cycle `illegal_o` pulse in the following cycle. It causes no write and leaves the decoder idle.
- R6: A word that arrives in the cycle `wr_o` is high from a serial command is ignored. It produces no `illegal_o` and does not start a command.
- R7: A core write request made while `ser_clk_act_i` is low and the serial decoder is idle produces `wr_o` for one cycle, in the next cycle, carrying the requested index and data.
- R8: A core write request made while `ser_clk_act_i` is high produces no write and a one-cycle `busy_err_o` pulse in the next cycle.
- R9: A core write request made while a serial command is in progress, including its write cycle, is rejected with a `busy_err_o` pulse in the next cycle. The serial write continues unaffected.
- R10: Operand words are taken as data even when they match the command pattern.
- R11: Serial and core writes never reach the write port in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_vld_i | input | 1 | A 16-bit word from the serial shifter is present this cycle |
| ser_word_i | input | 16 | Word from the serial shifter |
| ser_clk_act_i | input | 1 | Serial debug clock is active |
| core_wr_i | input | 1 | Core instruction requests a debug register write |
| core_idx_i | input | 4 | Register index for the core write |
| core_data_i | input | 32 | Data for the core write |
| wr_o | output | 1 | One-cycle write strobe to the register file |
| wr_idx_o | output | 4 | Register index of the write |
| wr_data_o | output | 32 | Data of the write |
| illegal_o | output | 1 | One-cycle pulse: unrecognised word received while idle |
| busy_err_o | output | 1 | One-cycle pulse: core write rejected |

## Verification
The decoder's state shows only through the timing of its pulses, so a wrong state appears at the ports within one to three serial words. A decoder stuck out of idle rejects the next core write with `busy_err_o`, and one that falls back to idle too early flags the following operand word as illegal. Operand halves that are swapped or latched in the wrong state show up in `wr_data_o` on the very write they belong to. Sweeping all 4096 upper-12-bit patterns, all 16 indices on both paths, and core requests in each decoder state confines any such fault to one word's time.

// File: rtl/dwd_pkg.sv
package dwd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_HI = 2'd1,
    ST_WAIT_LO = 2'd2,
    ST_WRITE   = 2'd3
  } dwd_state_e;

  localparam int unsigned DWD_OPCODE_DEF = 'h2C4;
endpackage

// File: rtl/dwd_ser_fsm.sv
module dwd_ser_fsm
  import dwd_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned OPCODE = DWD_OPCODE_DEF,
  localparam int unsigned DATA_W = 2 * WORD_W,
  localparam int unsigned OPC_W  = WORD_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [WORD_W-1:0] word_i,
  output dwd_state_e        st_o,
  output logic              idle_o,
  output logic              wr_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] data_o,
  output logic              illegal_o
);
  dwd_state_e        st_q, st_d;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;
  logic              ill_q;
  logic              opc_hit;

  assign opc_hit = (word_i[WORD_W-1:IDX_W] == OPC_W'(OPCODE));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (vld_i && opc_hit) st_d = ST_WAIT_HI;
      ST_WAIT_HI: if (vld_i)            st_d = ST_WAIT_LO;
      ST_WAIT_LO: if (vld_i)            st_d = ST_WRITE;
      ST_WRITE:                         st_d = ST_IDLE;
      default:                          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      data_q <= '0;
      ill_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ill_q <= (st_q == ST_IDLE) && vld_i && !opc_hit;
      if (vld_i) begin
        unique case (st_q)
          ST_IDLE:    if (opc_hit) idx_q <= word_i[IDX_W-1:0];
          ST_WAIT_HI: data_q[DATA_W-1:WORD_W] <= word_i;
          ST_WAIT_LO: data_q[WORD_W-1:0]      <= word_i;
          default: ;
        endcase
      end
    end
  end

  assign st_o      = st_q;
  assign idle_o    = (st_q == ST_IDLE);
  assign wr_o      = (st_q == ST_WRITE);
  assign idx_o     = idx_q;
  assign data_o    = data_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/dwd_core_gate.sv
module dwd_core_gate #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ser_clk_act_i,
  input  logic              ser_idle_i,
  output logic              wr_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_err_o
);
  logic              ok;
  logic              wr_q, err_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;

  // core path only while serial clock idle and no serial command in flight
  assign ok = !ser_clk_act_i && ser_idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      wr_q  <= req_i && ok;
      err_q <= req_i && !ok;
      if (req_i && ok) begin
        idx_q  <= idx_i;
        data_q <= data_i;
      end
    end
  end

  assign wr_o       = wr_q;
  assign idx_o      = idx_q;
  assign data_o     = data_q;
  assign busy_err_o = err_q;
endmodule

// File: rtl/dwd_wr_arb.sv
module dwd_wr_arb #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              ser_wr_i,
  input  logic [IDX_W-1:0]  ser_idx_i,
  input  logic [DATA_W-1:0] ser_data_i,
  input  logic              core_wr_i,
  input  logic [IDX_W-1:0]  core_idx_i,
  input  logic [DATA_W-1:0] core_data_i,
  output logic              wr_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] data_o
);
  // serial side wins; gating rules keep the two apart anyway
  always_comb begin
    wr_o   = ser_wr_i | core_wr_i;
    idx_o  = '0;
    data_o = '0;
    if (ser_wr_i) begin
      idx_o  = ser_idx_i;
      data_o = ser_data_i;
    end else if (core_wr_i) begin
      idx_o  = core_idx_i;
      data_o = core_data_i;
    end
  end
endmodule

// File: rtl/dbg_wr_decoder.sv
module dbg_wr_decoder
  import dwd_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned OPCODE = DWD_OPCODE_DEF,
  localparam int unsigned DATA_W = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_vld_i,
  input  logic [WORD_W-1:0] ser_word_i,
  input  logic              ser_clk_act_i,
  input  logic              core_wr_i,
  input  logic [IDX_W-1:0]  core_idx_i,
  input  logic [DATA_W-1:0] core_data_i,
  output logic              wr_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              illegal_o,
  output logic              busy_err_o
);
  dwd_state_e        ser_st;
  logic              ser_idle, ser_wr, core_wr;
  logic [IDX_W-1:0]  ser_idx, core_idx;
  logic [DATA_W-1:0] ser_data, core_data;

  dwd_ser_fsm #(.WORD_W(WORD_W), .IDX_W(IDX_W), .OPCODE(OPCODE)) u_ser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (ser_vld_i),
    .word_i    (ser_word_i),
    .st_o      (ser_st),
    .idle_o    (ser_idle),
    .wr_o      (ser_wr),
    .idx_o     (ser_idx),
    .data_o    (ser_data),
    .illegal_o (illegal_o)
  );

  dwd_core_gate #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_core (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (core_wr_i),
    .idx_i         (core_idx_i),
    .data_i        (core_data_i),
    .ser_clk_act_i (ser_clk_act_i),
    .ser_idle_i    (ser_idle),
    .wr_o          (core_wr),
    .idx_o         (core_idx),
    .data_o        (core_data),
    .busy_err_o    (busy_err_o)
  );

  dwd_wr_arb #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_arb (
    .ser_wr_i    (ser_wr),
    .ser_idx_i   (ser_idx),
    .ser_data_i  (ser_data),
    .core_wr_i   (core_wr),
    .core_idx_i  (core_idx),
    .core_data_i (core_data),
    .wr_o        (wr_o),
    .idx_o       (wr_idx_o),
    .data_o      (wr_data_o)
  );
endmodule

// File: rtl/dbg_wr_decoder_chk.sv
module dbg_wr_decoder_chk
  import dwd_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned OPCODE = DWD_OPCODE_DEF,
  localparam int unsigned DATA_W = 2 * WORD_W,
  localparam int unsigned OPC_W  = WORD_W - IDX_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ser_vld_i,
  input logic [WORD_W-1:0] ser_word_i,
  input logic              ser_clk_act_i,
  input logic              core_wr_i,
  input logic [IDX_W-1:0]  core_idx_i,
  input logic [DATA_W-1:0] core_data_i,
  input logic              wr_o,
  input logic [IDX_W-1:0]  wr_idx_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              illegal_o,
  input logic              busy_err_o,
  input dwd_state_e        ser_st,
  input logic              ser_wr,
  input logic              core_wr
);
  logic ser_idle_c, opc_c;
  assign ser_idle_c = (ser_st == ST_IDLE);
  assign opc_c      = (ser_word_i[WORD_W-1:IDX_W] == OPC_W'(OPCODE));

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_wr |=> !ser_wr);

  a_r4_write_after_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_wr |-> ($past(ser_st) == ST_WAIT_LO) && $past(ser_vld_i));

  a_r5_illegal_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_idle_c && ser_vld_i && !opc_c |=> illegal_o && (ser_st == ST_IDLE) && !wr_o);

  a_r6_write_ignores_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_wr |=> (ser_st == ST_IDLE) && !illegal_o);

  a_r7_core_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_wr_i && !ser_clk_act_i && ser_idle_c |=>
      wr_o && (wr_idx_o == $past(core_idx_i)) && (wr_data_o == $past(core_data_i)));

  a_r8_clk_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_wr_i && ser_clk_act_i |=> busy_err_o && !core_wr);

  a_r9_fsm_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_wr_i && !ser_idle_c |=> busy_err_o && !core_wr);

  a_r11_one_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ser_wr, core_wr}) <= 1);
endmodule

bind dbg_wr_decoder dbg_wr_decoder_chk #(
  .WORD_W(WORD_W), .IDX_W(IDX_W), .OPCODE(OPCODE)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ser_vld_i     (ser_vld_i),
  .ser_word_i    (ser_word_i),
  .ser_clk_act_i (ser_clk_act_i),
  .core_wr_i     (core_wr_i),
  .core_idx_i    (core_idx_i),
  .core_data_i   (core_data_i),
  .wr_o          (wr_o),
  .wr_idx_o      (wr_idx_o),
  .wr_data_o     (wr_data_o),
  .illegal_o     (illegal_o),
  .busy_err_o    (busy_err_o),
  .ser_st        (ser_st),
  .ser_wr        (ser_wr),
  .core_wr       (core_wr)
);

// File: tb/dbg_wr_decoder_tb_top.sv
module dbg_wr_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_vld = 1'b0;
  logic [15:0] ser_word = '0;
  logic        ser_act = 1'b0;
  logic        core_wr = 1'b0;
  logic [3:0]  core_idx = '0;
  logic [31:0] core_data = '0;
  logic        wr;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;
  logic        illegal, busy_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbg_wr_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ser_vld_i(ser_vld), .ser_word_i(ser_word), .ser_clk_act_i(ser_act),
    .core_wr_i(core_wr), .core_idx_i(core_idx), .core_data_i(core_data),
    .wr_o(wr), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .illegal_o(illegal), .busy_err_o(busy_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive one word at negedge; return at the next negedge (after the accepting edge)
  task automatic send(input logic [15:0] w);
    @(negedge clk);
    ser_vld = 1'b1; ser_word = w;
    @(negedge clk);
    ser_vld = 1'b0;
  endtask

  task automatic core_req(input logic [3:0] i, input logic [31:0] d);
    @(negedge clk);
    core_wr = 1'b1; core_idx = i; core_data = d;
    @(negedge clk);
    core_wr = 1'b0;
  endtask

  task automatic expect_write(input string req, input logic [3:0] i, input logic [31:0] d);
    chk(wr === 1'b1, req, {31'b0, wr}, 32'd1);
    chk(wr_idx === i, req, {28'b0, wr_idx}, {28'b0, i});
    chk(wr_data === d, req, wr_data, d);
  endtask

  task automatic expect_quiet(input string req);
    chk(wr === 1'b0, req, {31'b0, wr}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(wr === 1'b0 && illegal === 1'b0 && busy_err === 1'b0, "R1", {29'b0, wr, illegal, busy_err}, 32'd0);
    rst_n = 1'b1;
    core_req(4'h9, 32'hA5A5_0001);
    expect_write("R1 core write right after reset", 4'h9, 32'hA5A5_0001);
    @(negedge clk); expect_quiet("R7 pulse width");

    // R2 R3 all indices over serial
    for (int i = 0; i < 16; i++) begin
      d = 32'h1357_9BDF ^ (32'(i) * 32'h0111_1011);
      send(16'h2C40 | 16'(i));
      expect_quiet("R4 after cmd");
      send(d[31:16]);
      expect_quiet("R4 after hi");
      send(d[15:0]);
      expect_write("R2 R3 serial write", 4'(i), d);
      @(negedge clk); expect_quiet("R3 one cycle");
    end

    // R4 gaps between words
    send(16'h2C4B);
    repeat (3) begin @(negedge clk); expect_quiet("R4 gap"); end
    send(16'hDEAD);
    repeat (5) begin @(negedge clk); expect_quiet("R4 gap"); end
    send(16'hBEEF);
    expect_write("R4 gapped write", 4'hB, 32'hDEAD_BEEF);
    @(negedge clk);

    // R10 operand words matching opcode
    send(16'h2C45); send(16'h2C41); send(16'h2C42);
    expect_write("R10 operand as data", 4'h5, 32'h2C41_2C42);
    @(negedge clk);

    // R5 sweep all non-matching upper patterns
    for (int p = 0; p < 4096; p++) begin
      if (p != 'h2C4) begin
        send({12'(p), 4'(p)});
        chk(illegal === 1'b1, "R5 illegal pulse", {31'b0, illegal}, 32'd1);
        expect_quiet("R5 no write");
      end
    end
    @(negedge clk);
    chk(illegal === 1'b0, "R5 pulse width", {31'b0, illegal}, 32'd0);
    send(16'h2C43); send(16'h0102); send(16'h0304);
    expect_write("R5 idle after illegal", 4'h3, 32'h0102_0304);

    // R6 word during write cycle ignored, R9 core during write rejected
    @(negedge clk);
    send(16'h2C41); send(16'h1111); send(16'h2222);
    expect_write("R6 setup", 4'h1, 32'h1111_2222);
    ser_vld = 1'b1; ser_word = 16'h2C43; core_wr = 1'b1; core_idx = 4'h6; core_data = 32'h6666_6666;
    @(negedge clk);
    ser_vld = 1'b0; core_wr = 1'b0;
    chk(illegal === 1'b0, "R6 no illegal", {31'b0, illegal}, 32'd0);
    chk(busy_err === 1'b1, "R9 core during write", {31'b0, busy_err}, 32'd1);
    expect_quiet("R9 no core write");
    send(16'h2C47); send(16'hCAFE); send(16'hF00D);
    expect_write("R6 word ignored", 4'h7, 32'hCAFE_F00D);

    // R7 all core indices
    for (int i = 0; i < 16; i++) begin
      d = 32'hFEDC_0000 + 32'(i) * 32'h0001_0203;
      core_req(4'(i), d);
      expect_write("R7 core write", 4'(i), d);
      chk(busy_err === 1'b0, "R7 no busy", {31'b0, busy_err}, 32'd0);
    end

    // R8 serial clock active
    @(negedge clk); ser_act = 1'b1;
    core_req(4'h2, 32'h1234_5678);
    chk(busy_err === 1'b1, "R8 busy pulse", {31'b0, busy_err}, 32'd1);
    expect_quiet("R8 no write");
    @(negedge clk);
    chk(busy_err === 1'b0, "R8 pulse width", {31'b0, busy_err}, 32'd0);
    ser_act = 1'b0;

    // R9 core in WAIT_HI and WAIT_LO, R11 serial unaffected
    send(16'h2C4E);
    core_req(4'h4, 32'h4444_4444);
    chk(busy_err === 1'b1, "R9 wait_hi", {31'b0, busy_err}, 32'd1);
    send(16'hABCD);
    core_req(4'h4, 32'h4444_4444);
    chk(busy_err === 1'b1, "R9 wait_lo", {31'b0, busy_err}, 32'd1);
    expect_quiet("R11 no core write");
    send(16'h0123);
    expect_write("R9 R11 serial intact", 4'hE, 32'hABCD_0123);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule